// File: doc/BRIEF.md
# Two-Line Flash Prefetch Controller

This block sits between a core's 32-bit instruction fetch port and a flash that has a fixed number of wait states and returns 64-bit lines. It does not use a cache. It holds two line buffers. A fetch whose line is already in a buffer is answered in the same cycle. A fetch that misses loads its line from flash, and the line after it is then read into the other buffer ahead of need. As a result, straight-line code mostly runs without wait states.

The core supplies three kinds of information:

- **Branch-soon hint (`br_soon`).** This level may stay high for several cycles and belongs to no particular fetch. When it is high as a demand fill ends, the sequential prefetch is skipped. This keeps a prefetch from occupying the flash just as a branch target is needed.
- **Conditional-target flag (`fetch_cond`).** This marks a fetch as the target of a conditional branch. Such a fetch is normally held until the condition is known. When `SPEC_BACK` is set, a target below the last served address (a loop branch) is fetched speculatively instead.
- **Registered condition result (`cond_vld`, `cond_pass`).** This arrives one cycle after the conditional fetch is presented. If a speculative fill turns out to be wrong, its completion is hidden and appears on the port as an idle cycle.

Core-side contract: the core holds a fetch until `fetch_rdy` is high. It clears `fetch_cond` once the condition has resolved. It withdraws the fetch after a failed condition.

The controller has four states:

- `ST_IDLE`: serves hits.
- `ST_CWAIT`: holds a conditional fetch until the condition result arrives.
- `ST_FILL`: the demand line is being read from flash.
- `ST_PREF`: the next sequential line is being read; hits are still served.

The transitions are:

- IDLE→CWAIT on a conditional fetch that is not speculated.
- IDLE→FILL on a miss.
- CWAIT→IDLE when the condition fails, or when it passes and the fetch hits.
- CWAIT→FILL when the condition passes and the fetch misses.
- FILL→PREF at the end of a fill when a prefetch is allowed.
- FILL→IDLE at the end of a fill in every other case.
- PREF→IDLE when the prefetch completes.
- PREF→FILL on a miss to some other line; the prefetch is abandoned.
- PREF→CWAIT on a conditional fetch that is not speculated; the prefetch is abandoned.

Top module: `flash_line_prefetch`

## Requirements
- R1: After reset, `fetch_rdy` and `fl_req` are low and both buffers are empty, so the first fetch misses.
- R2: When the line tag `fetch_addr[31:3]` matches a valid buffer, `fetch_rdy` is high in the same cycle. `fetch_rdata` is bits [31:0] of the line when `fetch_addr[2]`=0 and bits [63:32] when it is 1.
- R3: On a miss, `fetch_rdy` stays low. `fl_req` is high for WAIT_ST+1 (2) cycles starting the cycle after the request, with `fl_line` = `fetch_addr[31:3]`. The word is served in the cycle after the last flash cycle.
- R4: When a demand fill ends, the next flash read is line+1 and starts the following cycle, into the other buffer. Afterwards both lines hit.
- R5: If `br_soon` is high in the last cycle of a demand fill, no prefetch starts: `fl_req` is low the next cycle.
- R6: A conditional fetch that is not speculated causes no flash read and no `fetch_rdy` until `cond_vld`. When `cond_pass`=1 it is then served (a hit in that same cycle) or filled. When `cond_pass`=0 nothing is fetched.
- R7: With SPEC_BACK=1, a conditional fetch whose address is below the last served address starts its fill at once. If `cond_vld` with `cond_pass`=0 arrives during the fill, `fetch_rdy` stays low when the fill ends and no prefetch follows.
- R8: A miss to a line other than the one being prefetched abandons the prefetch, even in the prefetch's final cycle. The demand line is on `fl_line` in the next cycle, and the abandoned line is not valid afterwards.
- R9: A miss to the line that is being prefetched waits without a new read. It is served in the cycle after the prefetch completes.
- R10: A demand fill replaces the buffer that did not supply the most recent hit or fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_req | input | 1 | Core fetch request |
| fetch_addr | input | ADDR_W | Fetch byte address |
| fetch_cond | input | 1 | Fetch is a conditional-branch target |
| fetch_rdy | output | 1 | Fetch served this cycle |
| fetch_rdata | output | DATA_W | Served instruction word |
| br_soon | input | 1 | Hint: a branch reaches execute soon |
| cond_vld | input | 1 | Registered condition result valid |
| cond_pass | input | 1 | Condition passed |
| fl_req | output | 1 | Flash read active |
| fl_line | output | ADDR_W-3 | Line address under read |
| fl_rdata | input | LINE_W | Flash line data, sampled in the last read cycle |

## Verification
Prefetch completion and a demand miss to a different line can fall in the same cycle. To provoke this, the bench presents a miss to an unrelated line in exactly the second cycle of a prefetch. In that cycle the buffer write and the restart of the flash read compete. The result is judged at the ports: `fl_line` must show the demand line in the next cycle, the demand word must be served after its fill, and a later fetch of the abandoned line must miss.

// File: rtl/flp_pkg.sv
package flp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CWAIT,
        ST_FILL,
        ST_PREF
    } flp_state_e;
endpackage

// File: rtl/flp_fill_timer.sv
module flp_fill_timer #(
    parameter int LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic load,
    output logic done
);
    localparam int CNT_W = (LAT > 1) ? $clog2(LAT) : 1;

    logic [CNT_W-1:0] cnt_q;

    assign done = run && (cnt_q == CNT_W'(LAT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load || done)
            cnt_q <= '0;
        else if (run)
            cnt_q <= cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/flp_line_buf.sv
module flp_line_buf #(
    parameter int TAG_W  = 29,
    parameter int LINE_W = 64,
    parameter int DATA_W = 32,
    parameter int WSEL_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inv,
    input  logic              wr,
    input  logic [TAG_W-1:0]  wtag,
    input  logic [LINE_W-1:0] wdata,
    input  logic [TAG_W-1:0]  look_tag,
    input  logic [WSEL_W-1:0] look_sel,
    output logic              hit,
    output logic [DATA_W-1:0] rword,
    output logic              vld,
    output logic [TAG_W-1:0]  tag
);
    logic [LINE_W-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld    <= 1'b0;
            tag    <= '0;
            data_q <= '0;
        end else if (wr) begin
            vld    <= 1'b1;
            tag    <= wtag;
            data_q <= wdata;
        end else if (inv) begin
            vld    <= 1'b0;
        end
    end

    assign hit   = vld && (tag == look_tag);
    assign rword = data_q[look_sel*DATA_W +: DATA_W];
endmodule

// File: rtl/flash_line_prefetch.sv
module flash_line_prefetch
    import flp_pkg::*;
#(
    parameter int   ADDR_W    = 32,
    parameter int   DATA_W    = 32,
    parameter int   LINE_W    = 64,
    parameter int   WAIT_ST   = 1,
    parameter logic SPEC_BACK = 1'b1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              fetch_req,
    input  logic [ADDR_W-1:0]                 fetch_addr,
    input  logic                              fetch_cond,
    output logic                              fetch_rdy,
    output logic [DATA_W-1:0]                 fetch_rdata,
    input  logic                              br_soon,
    input  logic                              cond_vld,
    input  logic                              cond_pass,
    output logic                              fl_req,
    output logic [ADDR_W-$clog2(LINE_W/8)-1:0] fl_line,
    input  logic [LINE_W-1:0]                 fl_rdata
);
    localparam int OFF_W  = $clog2(LINE_W / 8);
    localparam int BOFF_W = $clog2(DATA_W / 8);
    localparam int TAG_W  = ADDR_W - OFF_W;
    localparam int WSEL_W = (OFF_W - BOFF_W > 0) ? OFF_W - BOFF_W : 1;
    localparam int LAT    = WAIT_ST + 1;
    localparam int NBUF   = 2;

    flp_state_e state, nxt_state;

    logic [TAG_W-1:0]  fill_tag, ld_tag;
    logic              fill_buf, ld_buf, mru;
    logic              spec_fill, ld_spec, squash, fail_now;
    logic [ADDR_W-1:0] last_addr;
    logic              load, wr_en, serve, fill_done;

    logic [TAG_W-1:0]  look_tag;
    logic [WSEL_W-1:0] look_sel;
    logic [NBUF-1:0]   buf_hit, buf_vld, inv_vec, wr_vec;
    logic [DATA_W-1:0] buf_word [NBUF];
    logic [TAG_W-1:0]  buf_tag  [NBUF];
    logic              hit, hit_idx, spec_ok, must_wait, other_b, other_has_next;

    assign look_tag = fetch_addr[ADDR_W-1:OFF_W];
    assign look_sel = WSEL_W'(fetch_addr[OFF_W-1:BOFF_W]);

    for (genvar b = 0; b < NBUF; b++) begin : g_buf
        assign inv_vec[b] = load && (ld_buf == 1'(b));
        assign wr_vec[b]  = wr_en && (fill_buf == 1'(b));
        flp_line_buf #(
            .TAG_W (TAG_W),
            .LINE_W(LINE_W),
            .DATA_W(DATA_W),
            .WSEL_W(WSEL_W)
        ) u_buf (
            .clk     (clk),
            .rst_n   (rst_n),
            .inv     (inv_vec[b]),
            .wr      (wr_vec[b]),
            .wtag    (fill_tag),
            .wdata   (fl_rdata),
            .look_tag(look_tag),
            .look_sel(look_sel),
            .hit     (buf_hit[b]),
            .rword   (buf_word[b]),
            .vld     (buf_vld[b]),
            .tag     (buf_tag[b])
        );
    end

    flp_fill_timer #(.LAT(LAT)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (fl_req),
        .load (load),
        .done (fill_done)
    );

    assign hit            = |buf_hit;
    assign hit_idx        = buf_hit[1];
    assign spec_ok        = SPEC_BACK && (fetch_addr < last_addr);
    assign must_wait      = fetch_cond && !spec_ok;
    assign other_b        = ~fill_buf;
    assign other_has_next = buf_vld[other_b] && (buf_tag[other_b] == fill_tag + TAG_W'(1));
    assign fail_now       = spec_fill && cond_vld && !cond_pass;

    // state register and bookkeeping flops
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            fill_tag  <= '0;
            fill_buf  <= 1'b0;
            spec_fill <= 1'b0;
            squash    <= 1'b0;
            mru       <= 1'b0;
            last_addr <= '0;
        end else begin
            state <= nxt_state;
            if (load) begin
                fill_tag  <= ld_tag;
                fill_buf  <= ld_buf;
                spec_fill <= ld_spec;
                squash    <= 1'b0;
            end else if (state == ST_FILL && fail_now) begin
                squash <= 1'b1;
            end
            if (serve) begin
                mru       <= hit_idx;
                last_addr <= fetch_addr;
            end else if (wr_en && state == ST_FILL) begin
                mru <= fill_buf;
            end
        end
    end

    // next state and outputs
    always_comb begin
        nxt_state = state;
        serve     = 1'b0;
        load      = 1'b0;
        wr_en     = 1'b0;
        ld_tag    = look_tag;
        ld_buf    = ~mru;
        ld_spec   = fetch_cond && spec_ok;
        unique case (state)
            ST_IDLE: begin
                if (fetch_req) begin
                    if (must_wait) begin
                        nxt_state = ST_CWAIT;
                    end else if (hit) begin
                        serve = 1'b1;
                    end else begin
                        load      = 1'b1;
                        nxt_state = ST_FILL;
                    end
                end
            end
            ST_CWAIT: begin
                ld_spec = 1'b0;
                if (cond_vld) begin
                    if (!cond_pass || !fetch_req) begin
                        nxt_state = ST_IDLE;
                    end else if (hit) begin
                        serve     = 1'b1;
                        nxt_state = ST_IDLE;
                    end else begin
                        load      = 1'b1;
                        nxt_state = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                if (fill_done) begin
                    wr_en = 1'b1;
                    if (squash || fail_now || br_soon || other_has_next) begin
                        nxt_state = ST_IDLE;
                    end else begin
                        load      = 1'b1;
                        ld_tag    = fill_tag + TAG_W'(1);
                        ld_buf    = ~fill_buf;
                        ld_spec   = 1'b0;
                        nxt_state = ST_PREF;
                    end
                end
            end
            ST_PREF: begin
                if (fetch_req && must_wait) begin
                    nxt_state = ST_CWAIT;
                end else if (fetch_req && !hit && look_tag != fill_tag) begin
                    load      = 1'b1;
                    ld_buf    = fill_buf;
                    nxt_state = ST_FILL;
                end else begin
                    serve = fetch_req && hit;
                    if (fill_done) begin
                        wr_en     = 1'b1;
                        nxt_state = ST_IDLE;
                    end
                end
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    assign fetch_rdy   = serve;
    assign fetch_rdata = buf_word[hit_idx];
    assign fl_req      = (state == ST_FILL) || (state == ST_PREF);
    assign fl_line     = fill_tag;
endmodule

// File: rtl/flp_checker.sv
module flp_checker
    import flp_pkg::*;
#(
    parameter int TAG_W = 29,
    parameter int LAT   = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fetch_req,
    input logic             fetch_rdy,
    input logic             fl_req,
    input logic [TAG_W-1:0] fl_line,
    input logic             cond_vld,
    input logic             br_soon,
    input flp_state_e       state,
    input logic             squash,
    input logic             fill_done,
    input logic [1:0]       buf_hit
);
    logic             prev_req;
    logic [TAG_W-1:0] prev_line;
    logic [7:0]       len_q, len_now;

    always_comb begin
        if (!fl_req)
            len_now = 8'd0;
        else if (prev_req && fl_line == prev_line)
            len_now = len_q + 8'd1;
        else
            len_now = 8'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_req  <= 1'b0;
            prev_line <= '0;
            len_q     <= 8'd0;
        end else begin
            prev_req  <= fl_req;
            prev_line <= fl_line;
            len_q     <= len_now;
        end
    end

    p_rdy_has_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_rdy |-> fetch_req);

    p_fill_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req |-> (len_now <= 8'(LAT)));

    p_fill_no_rdy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL) |-> !fetch_rdy);

    p_soon_blocks_pf_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL && fill_done && br_soon) |=> !fl_req);

    p_cwait_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CWAIT) |-> (!fl_req && (cond_vld || !fetch_rdy)));

    p_squash_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL && fill_done && squash) |=> (!fl_req && !fetch_rdy));

    p_one_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(buf_hit));
endmodule

bind flash_line_prefetch flp_checker #(
    .TAG_W(TAG_W),
    .LAT  (LAT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fetch_req(fetch_req),
    .fetch_rdy(fetch_rdy),
    .fl_req   (fl_req),
    .fl_line  (fl_line),
    .cond_vld (cond_vld),
    .br_soon  (br_soon),
    .state    (state),
    .squash   (squash),
    .fill_done(fill_done),
    .buf_hit  (buf_hit)
);

// File: tb/sim_flash_line_prefetch.sv
module sim_flash_line_prefetch;
    localparam int CLK_P = 10;
    localparam logic [31:0] KEY = 32'h5A5A_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_req = 1'b0, fetch_cond = 1'b0, br_soon = 1'b0;
    logic        cond_vld = 1'b0, cond_pass = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        fetch_rdy, fl_req;
    logic [31:0] fetch_rdata;
    logic [28:0] fl_line;
    logic [63:0] fl_rdata;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_P / 2) clk = ~clk;

    function automatic logic [31:0] exp_word(input logic [31:0] a);
        return {a[31:2], 2'b00} ^ KEY;
    endfunction

    // flash model: line contents are a fixed function of the line address
    assign fl_rdata = {exp_word({fl_line, 3'b100}), exp_word({fl_line, 3'b000})};

    flash_line_prefetch u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_req  (fetch_req),
        .fetch_addr (fetch_addr),
        .fetch_cond (fetch_cond),
        .fetch_rdy  (fetch_rdy),
        .fetch_rdata(fetch_rdata),
        .br_soon    (br_soon),
        .cond_vld   (cond_vld),
        .cond_pass  (cond_pass),
        .fl_req     (fl_req),
        .fl_line    (fl_line),
        .fl_rdata   (fl_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // one cycle: drive after the falling edge, settle, then the caller samples
    task automatic cyc(input logic rq, input logic [31:0] a, input logic c,
                       input logic s, input logic cv, input logic cp);
        @(negedge clk);
        fetch_req  = rq;
        fetch_addr = a;
        fetch_cond = c;
        br_soon    = s;
        cond_vld   = cv;
        cond_pass  = cp;
        #1;
    endtask

    task automatic idle(input int n, input logic s);
        for (int i = 0; i < n; i++) cyc(1'b0, 32'h0, 1'b0, s, 1'b0, 1'b0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 rdy after reset", {31'd0, fetch_rdy}, 32'd0);
        chk("R1 fl_req after reset", {31'd0, fl_req}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_miss_prefetch;
        cyc(1, 32'h100, 0, 0, 0, 0);
        chk("R1 first fetch misses", {31'd0, fetch_rdy}, 32'd0);
        cyc(1, 32'h100, 0, 0, 0, 0);
        chk("R3 fl_req", {31'd0, fl_req}, 32'd1);
        chk("R3 fl_line", {3'd0, fl_line}, 32'h20);
        cyc(1, 32'h100, 0, 0, 0, 0);
        chk("R3 still stalled", {31'd0, fetch_rdy}, 32'd0);
        cyc(1, 32'h100, 0, 0, 0, 0);
        chk("R3 served after fill", {31'd0, fetch_rdy}, 32'd1);
        chk("R2 lower word", fetch_rdata, exp_word(32'h100));
        chk("R4 prefetch line", {3'd0, fl_line}, 32'h21);
        cyc(1, 32'h104, 0, 0, 0, 0);
        chk("R2 upper word hit", {31'd0, fetch_rdy}, 32'd1);
        chk("R2 upper word", fetch_rdata, exp_word(32'h104));
        cyc(1, 32'h108, 0, 0, 0, 0);
        chk("R4 next line hits", {31'd0, fetch_rdy}, 32'd1);
        chk("R4 next line data", fetch_rdata, exp_word(32'h108));
        chk("R4 flash idle", {31'd0, fl_req}, 32'd0);
        idle(1, 0);
    endtask

    task automatic t_suppress;
        cyc(1, 32'h200, 0, 1, 0, 0);
        cyc(1, 32'h200, 0, 1, 0, 0);
        cyc(1, 32'h200, 0, 1, 0, 0);
        cyc(1, 32'h200, 0, 0, 0, 0);
        chk("R5 demand served", {31'd0, fetch_rdy}, 32'd1);
        chk("R5 no prefetch", {31'd0, fl_req}, 32'd0);
        cyc(1, 32'h208, 0, 0, 0, 0);
        chk("R5 next line not fetched", {31'd0, fetch_rdy}, 32'd0);
        idle(6, 0);
    endtask

    task automatic t_replace;
        cyc(1, 32'h210, 0, 0, 0, 0);
        chk("R10 hit 0x210", {31'd0, fetch_rdy}, 32'd1);
        cyc(1, 32'h280, 0, 1, 0, 0);
        cyc(1, 32'h280, 0, 1, 0, 0);
        cyc(1, 32'h280, 0, 1, 0, 0);
        cyc(1, 32'h210, 0, 1, 0, 0);
        chk("R10 recent line kept", {31'd0, fetch_rdy}, 32'd1);
        cyc(1, 32'h280, 0, 1, 0, 0);
        chk("R10 new line hits", fetch_rdata, exp_word(32'h280));
        cyc(1, 32'h208, 0, 1, 0, 0);
        chk("R10 older line evicted", {31'd0, fetch_rdy}, 32'd0);
        idle(4, 1);
        idle(1, 0);
    endtask

    task automatic t_cond_wait;
        cyc(1, 32'h300, 1, 0, 0, 0);
        cyc(1, 32'h300, 1, 0, 0, 0);
        chk("R6 no fetch while waiting", {30'd0, fl_req, fetch_rdy}, 32'd0);
        cyc(1, 32'h300, 1, 0, 1, 0);
        chk("R6 fail not served", {31'd0, fetch_rdy}, 32'd0);
        cyc(0, 32'h0, 0, 0, 0, 0);
        chk("R6 fail no flash read", {31'd0, fl_req}, 32'd0);
        cyc(1, 32'h284, 1, 0, 0, 0);
        chk("R6 hit held until condition", {31'd0, fetch_rdy}, 32'd0);
        cyc(1, 32'h284, 1, 0, 1, 1);
        chk("R6 pass served", {31'd0, fetch_rdy}, 32'd1);
        chk("R6 pass data", fetch_rdata, exp_word(32'h284));
        cyc(1, 32'h404, 1, 0, 0, 0);
        cyc(1, 32'h404, 1, 0, 1, 1);
        chk("R6 pass miss stalls", {31'd0, fetch_rdy}, 32'd0);
        cyc(1, 32'h404, 0, 1, 0, 0);
        chk("R6 fill line", {3'd0, fl_line}, 32'h80);
        cyc(1, 32'h404, 0, 1, 0, 0);
        cyc(1, 32'h404, 0, 0, 0, 0);
        chk("R6 filled word", fetch_rdata, exp_word(32'h404));
        idle(1, 0);
    endtask

    task automatic t_spec_back;
        cyc(1, 32'h100, 1, 0, 0, 0);
        cyc(1, 32'h100, 1, 0, 1, 0);
        chk("R7 speculative read started", {31'd0, fl_req}, 32'd1);
        cyc(0, 32'h0, 0, 0, 0, 0);
        cyc(0, 32'h0, 0, 0, 0, 0);
        chk("R7 squashed: idle", {30'd0, fl_req, fetch_rdy}, 32'd0);
        cyc(1, 32'h180, 1, 0, 0, 0);
        cyc(1, 32'h180, 0, 0, 1, 1);
        cyc(1, 32'h180, 0, 0, 0, 0);
        cyc(1, 32'h180, 0, 0, 0, 0);
        chk("R7 pass served", fetch_rdata, exp_word(32'h180));
        idle(3, 0);
    endtask

    task automatic t_abort;
        cyc(1, 32'h600, 0, 0, 0, 0);
        cyc(1, 32'h600, 0, 0, 0, 0);
        cyc(1, 32'h600, 0, 0, 0, 0);
        cyc(1, 32'h600, 0, 0, 0, 0);
        chk("R8 demand served", {31'd0, fetch_rdy}, 32'd1);
        cyc(1, 32'h700, 0, 0, 0, 0);
        chk("R8 prefetch running", {3'd0, fl_line}, 32'hC1);
        chk("R8 branch miss stalls", {31'd0, fetch_rdy}, 32'd0);
        cyc(1, 32'h700, 0, 1, 0, 0);
        chk("R8 demand line next", {3'd0, fl_line}, 32'hE0);
        cyc(1, 32'h700, 0, 1, 0, 0);
        cyc(1, 32'h700, 0, 1, 0, 0);
        chk("R8 branch target data", fetch_rdata, exp_word(32'h700));
        cyc(1, 32'h608, 0, 1, 0, 0);
        chk("R8 abandoned line misses", {31'd0, fetch_rdy}, 32'd0);
        idle(4, 1);
        idle(1, 0);
    endtask

    task automatic t_wait_pref;
        cyc(1, 32'h800, 0, 0, 0, 0);
        cyc(1, 32'h800, 0, 0, 0, 0);
        cyc(1, 32'h800, 0, 0, 0, 0);
        cyc(1, 32'h808, 0, 0, 0, 0);
        chk("R9 waits on prefetch", {31'd0, fetch_rdy}, 32'd0);
        chk("R9 prefetch line", {3'd0, fl_line}, 32'h101);
        cyc(1, 32'h808, 0, 0, 0, 0);
        cyc(1, 32'h808, 0, 0, 0, 0);
        chk("R9 served after prefetch", fetch_rdata, exp_word(32'h808));
        chk("R9 no new read", {30'd0, fl_req, fetch_rdy}, 32'd1);
        idle(2, 0);
    endtask

    initial begin
        t_reset();
        t_miss_prefetch();
        t_suppress();
        t_replace();
        t_cond_wait();
        t_spec_back();
        t_abort();
        t_wait_pref();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule